// File: doc/BRIEF.md
# Single-Accumulator Word-Addressed CPU Core

This block is a small stored-program processor built around one 32-bit accumulator, a 12-bit instruction counter and an internal memory of 4096 words of 32 bits. Every instruction word has the same layout: a sign bit that modifies a few operations, a 4-bit operation code and a 12-bit operand address. The core fetches the word at the counter, advances the counter, then carries out one of the loads, stores, address-field rewrites, jumps, arithmetic or logical operations. Multiply and divide treat the accumulator and the operand as signed binary fractions.

The core sits idle after reset. The surrounding logic (in practice the testbench) writes a program and its data through a load port while the core is idle, then pulses `start`. The core runs until a stop instruction or an arithmetic overflow halts it. It then reports why on `halt_reason`, and its accumulator, counter and any memory word stay readable. A later `start` resumes at the word after the one that halted. A transfer switch input qualifies the conditional jump. Four breakpoint switch inputs can turn selected stop instructions into no-ops.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous reset clears the accumulator and the counter to 0 and leaves the core idle. After reset, `halted` is 1 and `halt_reason` is 0. Reason codes are 0 for none, 1 for a stop instruction and 2 for an overflow.
- R2: A `start` pulse while the core is idle drops `halted` and clears `halt_reason`, then fetching begins at the current counter. Each instruction takes exactly two clock cycles: a fetch cycle that also advances the counter by one, and an execute cycle.
- R3: An instruction word carries the sign bit in bit 31, the opcode in bits [19:16] and the operand address in bits [13:2]. All other bits are ignored.
- R4: Bit 0 of every memory word is forced to 0 when the word is written and when it is read, on the load port, the peek port and the core's own accesses.
- R5: Opcode 1 loads the accumulator from memory. Opcode 0xC stores the accumulator. Opcode 0xD stores the accumulator and then clears it. Opcode 9 ANDs the accumulator with memory.
- R6: Opcode 0xE adds memory to the accumulator and opcode 0xF subtracts memory from it. A signed two's-complement overflow still writes the wrapped result, then halts with reason 2 and the counter past that instruction.
- R7: Opcode 2 replaces only bits [13:2] of the addressed word with bits [13:2] of the accumulator. Every other bit of the word is kept.
- R8: Opcode 3 writes the already-advanced counter plus one into bits [13:2] of the addressed word. Every other bit is kept.
- R9: Opcode 0xA always loads the operand address into the counter. Opcode 0xB does so only when accumulator bit 31 is 1, or when instruction bit 31 is 1 and `t_switch` is 1.
- R10: Opcode 6 puts the low 32 bits of the signed 64-bit product in the accumulator. Opcode 7 puts bits [62:32] of that product in accumulator bits [31:1], with bit 0 set to 0.
- R11: Opcode 5 divides. If the magnitude of the accumulator is at least the magnitude of the operand, the core halts with reason 2 and the accumulator is unchanged. Otherwise the result is floor(|A|·2^31/|M|) plus one with bit 0 cleared, negated when the operand signs differ.
- R12: Opcode 0 halts with reason 1 unless an address bit 11, 10, 9 or 8 that is set meets a set `bp_sw` bit 3, 2, 1 or 0 respectively. In that case the instruction does nothing. A later `start` resumes at the next word.
- R13: Opcodes 4 and 8 change neither the accumulator nor memory, and execution moves on to the next word.
- R14: While halted with `start` low, the accumulator and the counter hold their values whatever `t_switch` and `bp_sw` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Leaves the idle state and begins fetching at the counter |
| t_switch | input | 1 | Transfer switch for the signed conditional jump |
| bp_sw | input | 4 | Breakpoint switches that suppress matching stops |
| load_we | input | 1 | Memory write strobe for preloading while idle |
| load_addr | input | 12 | Memory write address |
| load_data | input | 32 | Memory write data |
| peek_addr | input | 12 | Memory read address for observation |
| peek_data | output | 32 | Memory word at `peek_addr`, combinational |
| halted | output | 1 | Core is idle |
| halt_reason | output | 2 | Why the core last halted |
| acc_out | output | 32 | Accumulator |
| pc_out | output | 12 | Instruction counter |

## Verification
After a `start` pulse, `halted` goes low by the next edge. For a program of N executed instructions it returns high exactly 2·N edges after the edge that took `start`. The bench counts falling edges from that point and compares the count with twice the number of instructions it expects to run, including the shorter run when an overflow ends the program early. Accumulator, counter and reason are sampled at the falling edge where `halted` is first seen high. Memory results are read on the combinational peek port one time step after a falling edge, so no result depends on the order of events at a rising edge.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int OPC_W    = 4;
    localparam int OPC_LSB  = 16;
    localparam int EA_LSB   = 2;
    localparam int SIGN_BIT = WORD_W - 1;
    localparam int BP_W     = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OPC_W-1:0] {
        OP_STOP   = 4'h0,
        OP_LOAD   = 4'h1,
        OP_SETADR = 4'h2,
        OP_LINK   = 4'h3,
        OP_IN     = 4'h4,
        OP_DIV    = 4'h5,
        OP_MULLO  = 4'h6,
        OP_MULHI  = 4'h7,
        OP_OUT    = 4'h8,
        OP_AND    = 4'h9,
        OP_JMP    = 4'hA,
        OP_JNEG   = 4'hB,
        OP_STORE  = 4'hC,
        OP_STCLR  = 4'hD,
        OP_ADD    = 4'hE,
        OP_SUB    = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        RSN_NONE = 2'd0,
        RSN_STOP = 2'd1,
        RSN_OVF  = 2'd2
    } reason_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_EXEC  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e  phase;
        word_t   acc;
        addr_t   pc;
        word_t   ir;
        reason_e reason;
    } core_st_t;

    localparam core_st_t ST_RESET = '{
        phase:  PH_IDLE,
        acc:    '0,
        pc:     '0,
        ir:     '0,
        reason: RSN_NONE
    };

    localparam word_t EA_MASK = word_t'(((1 << ADDR_W) - 1) << EA_LSB);

    function automatic addr_t ir_ea(input word_t w);
        return w[EA_LSB +: ADDR_W];
    endfunction

    function automatic opcode_e ir_op(input word_t w);
        return opcode_e'(w[OPC_LSB +: OPC_W]);
    endfunction

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int AW  = 12,
    parameter int DW  = 32,
    parameter int NRD = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);

    localparam int          DEPTH = 1 << AW;
    localparam logic [DW-1:0] KEEP = ~(DW'(1));

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata & KEEP;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = cells[raddr[p]] & KEEP;
    end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  opcode_e op,
    input  word_t   acc,
    input  word_t   opnd,
    output word_t   result,
    output logic    ovf
);

    localparam int S  = SIGN_BIT;
    localparam int PW = 2 * WORD_W - 1;
    localparam int QB = WORD_W - 1;

    word_t           sum, diff, mag_a, mag_m, rnd, quotient;
    logic            add_ovf, sub_ovf, div_ovf;
    logic [PW-1:0]   prod;
    logic [WORD_W:0] rem;
    logic [QB-1:0]   q;

    always_comb begin
        sum     = acc + opnd;
        diff    = acc - opnd;
        add_ovf = (acc[S] == opnd[S]) && (sum[S] != acc[S]);
        sub_ovf = (acc[S] != opnd[S]) && (diff[S] != acc[S]);
        prod    = {{(WORD_W-1){acc[S]}}, acc} * {{(WORD_W-1){opnd[S]}}, opnd};
    end

    always_comb begin
        mag_a   = acc[S]  ? -acc  : acc;
        mag_m   = opnd[S] ? -opnd : opnd;
        div_ovf = (mag_a >= mag_m);
        rem     = {1'b0, mag_a};
        q       = '0;
        for (int i = 0; i < QB; i++) begin
            rem = rem << 1;
            if (rem >= {1'b0, mag_m}) begin
                rem = rem - {1'b0, mag_m};
                q   = {q[QB-2:0], 1'b1};
            end else begin
                q   = {q[QB-2:0], 1'b0};
            end
        end
        rnd      = ({1'b0, q} + word_t'(1)) & ~word_t'(1);
        quotient = (acc[S] ^ opnd[S]) ? -rnd : rnd;
    end

    always_comb begin
        result = acc;
        ovf    = 1'b0;
        case (op)
            OP_AND:   result = acc & opnd;
            OP_ADD:   begin result = sum;  ovf = add_ovf; end
            OP_SUB:   begin result = diff; ovf = sub_ovf; end
            OP_MULLO: result = prod[WORD_W-1:0];
            OP_MULHI: result = {prod[PW-1:WORD_W], 1'b0};
            OP_DIV:   begin result = div_ovf ? acc : quotient; ovf = div_ovf; end
            default:  result = acc;
        endcase
    end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            t_switch,
    input  logic [BP_W-1:0] bp_sw,
    input  word_t           mem_rdata,
    input  word_t           alu_result,
    input  logic            alu_ovf,
    output addr_t           mem_raddr,
    output logic            mem_we,
    output word_t           mem_wdata,
    output opcode_e         cur_op,
    output word_t           acc,
    output addr_t           pc,
    output logic            halted,
    output logic [1:0]      reason
);

    core_st_t st_q, st_d;
    addr_t    ea;
    logic     bp_hit, take;

    assign cur_op = ir_op(st_q.ir);
    assign ea     = ir_ea(st_q.ir);

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_wdata = st_q.acc;
        mem_raddr = (st_q.phase == PH_FETCH) ? st_q.pc : ea;
        bp_hit    = |(ea[ADDR_W-1 -: BP_W] & bp_sw);
        take      = st_q.acc[SIGN_BIT] | (st_q.ir[SIGN_BIT] & t_switch);

        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase  = PH_FETCH;
                    st_d.reason = RSN_NONE;
                end
            end
            PH_FETCH: begin
                st_d.ir    = mem_rdata;
                st_d.pc    = st_q.pc + addr_t'(1);
                st_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                st_d.phase = PH_FETCH;
                case (cur_op)
                    OP_STOP: begin
                        if (!bp_hit) begin
                            st_d.phase  = PH_IDLE;
                            st_d.reason = RSN_STOP;
                        end
                    end
                    OP_LOAD: st_d.acc = mem_rdata;
                    OP_SETADR: begin
                        mem_we    = 1'b1;
                        mem_wdata = (mem_rdata & ~EA_MASK) | (st_q.acc & EA_MASK);
                    end
                    OP_LINK: begin
                        mem_we    = 1'b1;
                        mem_wdata = (mem_rdata & ~EA_MASK)
                                  | (word_t'(st_q.pc + addr_t'(1)) << EA_LSB);
                    end
                    OP_JMP:  st_d.pc = ea;
                    OP_JNEG: if (take) st_d.pc = ea;
                    OP_STORE: mem_we = 1'b1;
                    OP_STCLR: begin
                        mem_we   = 1'b1;
                        st_d.acc = '0;
                    end
                    OP_AND, OP_ADD, OP_SUB, OP_MULLO, OP_MULHI, OP_DIV: begin
                        st_d.acc = alu_result;
                        if (alu_ovf) begin
                            st_d.phase  = PH_IDLE;
                            st_d.reason = RSN_OVF;
                        end
                    end
                    default: st_d.acc = st_q.acc;
                endcase
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc    = st_q.acc;
    assign pc     = st_q.pc;
    assign halted = (st_q.phase == PH_IDLE);
    assign reason = st_q.reason;

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              t_switch,
    input  logic [BP_W-1:0]   bp_sw,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [WORD_W-1:0] peek_data,
    output logic              halted,
    output logic [1:0]        halt_reason,
    output logic [WORD_W-1:0] acc_out,
    output logic [ADDR_W-1:0] pc_out
);

    localparam int NRD = 2;

    addr_t   core_raddr;
    logic    core_we;
    word_t   core_wdata;
    opcode_e cur_op;
    word_t   alu_result;
    logic    alu_ovf;
    addr_t   rd_addr [NRD];
    word_t   rd_data [NRD];

    assign rd_addr[0] = core_raddr;
    assign rd_addr[1] = peek_addr;
    assign peek_data  = rd_data[1];

    acc_cpu_mem #(
        .AW  (ADDR_W),
        .DW  (WORD_W),
        .NRD (NRD)
    ) i_mem (
        .clk   (clk),
        .we    (core_we | load_we),
        .waddr (core_we ? core_raddr : load_addr),
        .wdata (core_we ? core_wdata : load_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    acc_cpu_alu i_alu (
        .op     (cur_op),
        .acc    (acc_out),
        .opnd   (rd_data[0]),
        .result (alu_result),
        .ovf    (alu_ovf)
    );

    acc_cpu_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .t_switch   (t_switch),
        .bp_sw      (bp_sw),
        .mem_rdata  (rd_data[0]),
        .alu_result (alu_result),
        .alu_ovf    (alu_ovf),
        .mem_raddr  (core_raddr),
        .mem_we     (core_we),
        .mem_wdata  (core_wdata),
        .cur_op     (cur_op),
        .acc        (acc_out),
        .pc         (pc_out),
        .halted     (halted),
        .reason     (halt_reason)
    );

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        halted,
    input logic [1:0]  halt_reason,
    input logic [31:0] acc_out,
    input logic [11:0] pc_out,
    input logic [31:0] peek_data
);

    // R2
    leave_idle_only_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(halted) |-> $past(start));

    // R12
    halt_has_reason_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> (halt_reason == 2'd1 || halt_reason == 2'd2));

    // R6
    reason_only_when_halted_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_reason != 2'd0) |-> halted);

    // R14
    idle_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> ($stable(acc_out) && $stable(pc_out)));

    // R4
    even_word_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (peek_data[0] == 1'b0));

endmodule

bind acc_cpu_core acc_cpu_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .halted      (halted),
    .halt_reason (halt_reason),
    .acc_out     (acc_out),
    .pc_out      (pc_out),
    .peek_data   (peek_data)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        t_switch = 1'b0;
    logic [3:0]  bp_sw = 4'd0;
    logic        load_we = 1'b0;
    logic [11:0] load_addr = 12'd0;
    logic [31:0] load_data = 32'd0;
    logic [11:0] peek_addr = 12'd0;
    logic [31:0] peek_data;
    logic        halted;
    logic [1:0]  halt_reason;
    logic [31:0] acc_out;
    logic [11:0] pc_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acc_cpu_core i_acc_cpu_core (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .t_switch    (t_switch),
        .bp_sw       (bp_sw),
        .load_we     (load_we),
        .load_addr   (load_addr),
        .load_data   (load_data),
        .peek_addr   (peek_addr),
        .peek_data   (peek_data),
        .halted      (halted),
        .halt_reason (halt_reason),
        .acc_out     (acc_out),
        .pc_out      (pc_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input logic sg, input logic [11:0] ea);
        return {sg, 11'd0, op, 2'd0, ea, 2'd0};
    endfunction

    task automatic reset_core();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic poke(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        load_we   = 1'b1;
        load_addr = a;
        load_data = d;
        @(negedge clk);
        load_we   = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        peek_addr = a;
        #1;
        d = peek_data;
    endtask

    task automatic run_prog(output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!halted && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) begin
            checks++;
            errors++;
            $display("FAIL R2 run did not halt actual %0d expected below 400", cyc);
        end
    endtask

    function automatic logic [31:0] rnd_word();
        logic [31:0] w;
        case ($urandom % 4)
            0: w = $urandom;
            1: w = $urandom % 2000;
            2: w = 32'h7FFF_0000 | ($urandom % 65536);
            default: w = 32'h8000_0000 | ($urandom % 65536);
        endcase
        return w;
    endfunction

    function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] m,
                                  output logic [31:0] res, output logic ovf);
        longint      sa, sm, r;
        logic [31:0] am, mm, qq;
        logic [63:0] q64;
        sa  = longint'($signed(a));
        sm  = longint'($signed(m));
        ovf = 1'b0;
        res = a;
        case (op)
            4'h1: res = m;
            4'h9: res = a & m;
            4'hC: res = a;
            4'hD: res = 32'd0;
            4'hE: begin r = sa + sm; res = r[31:0]; ovf = (r > 64'sd2147483647) || (r < -64'sd2147483648); end
            4'hF: begin r = sa - sm; res = r[31:0]; ovf = (r > 64'sd2147483647) || (r < -64'sd2147483648); end
            4'h6: begin r = sa * sm; res = r[31:0]; end
            4'h7: begin r = sa * sm; res = {r[62:32], 1'b0}; end
            4'h5: begin
                am = a[31] ? -a : a;
                mm = m[31] ? -m : m;
                if (am >= mm) begin
                    ovf = 1'b1;
                    res = a;
                end else begin
                    q64 = ({32'd0, am} << 31) / {32'd0, mm};
                    qq  = q64[31:0] + 32'd1;
                    qq[0] = 1'b0;
                    res = (a[31] ^ m[31]) ? -qq : qq;
                end
            end
            default: res = a;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'hE, 4'hF: return "R6";
            4'h6, 4'h7: return "R10";
            4'h5:       return "R11";
            default:    return "R5";
        endcase
    endfunction

    task automatic one_op(input logic [3:0] op, input logic [31:0] av, input logic [31:0] mv);
        logic [31:0] a0, m0, er, w;
        logic        eo;
        int          cyc;
        string       tg;
        a0 = av & ~32'd1;
        m0 = mv & ~32'd1;
        model(op, a0, m0, er, eo);
        tg = tag_of(op);
        reset_core();
        poke(12'd100, av);
        poke(12'd101, mv);
        poke(12'd0, mk(4'h1, 1'b0, 12'd100));
        poke(12'd1, mk(op, 1'b0, 12'd101));
        poke(12'd2, mk(4'h0, 1'b0, 12'd0));
        run_prog(cyc);
        chk({tg, " acc"}, acc_out, er);
        chk({tg, " reason"}, {30'd0, halt_reason}, eo ? 32'd2 : 32'd1);
        chk({tg, " pc"}, {20'd0, pc_out}, eo ? 32'd2 : 32'd3);
        chk("R2 cycles", cyc, eo ? 32'd4 : 32'd6);
        peek(12'd101, w);
        chk({tg, " operand word"}, w, (op == 4'hC || op == 4'hD) ? a0 : m0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected halted");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w, a_keep;
        logic [11:0] p_keep;
        logic [3:0]  ops [9];
        int          cyc;
        ops = '{4'h1, 4'h9, 4'hE, 4'hF, 4'h6, 4'h7, 4'h5, 4'hC, 4'hD};
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 halted", {31'd0, halted}, 32'd1);
        chk("R1 reason", {30'd0, halt_reason}, 32'd0);
        chk("R1 acc", acc_out, 32'd0);
        chk("R1 pc", {20'd0, pc_out}, 32'd0);

        // R4 odd word stored and read even, also through a load
        poke(12'd50, 32'h1234_5679);
        peek(12'd50, w);
        chk("R4 peek", w, 32'h1234_5678);
        poke(12'd0, mk(4'h1, 1'b0, 12'd50));
        poke(12'd1, mk(4'h0, 1'b0, 12'd0));
        run_prog(cyc);
        chk("R4 load", acc_out, 32'h1234_5678);
        // R3 opcode and address fields decode
        chk("R3 pc after two words", {20'd0, pc_out}, 32'd2);

        // R7 address-field rewrite
        reset_core();
        poke(12'd70, 32'hFFFF_FFFF);
        poke(12'd71, 32'h0F0F_A5A4);
        poke(12'd0, mk(4'h1, 1'b0, 12'd71));
        poke(12'd1, mk(4'h2, 1'b0, 12'd70));
        poke(12'd2, mk(4'h0, 1'b0, 12'd0));
        run_prog(cyc);
        peek(12'd70, w);
        chk("R7 merged word", w, (32'hFFFF_FFFE & ~32'h0000_3FFC) | (32'h0F0F_A5A4 & 32'h0000_3FFC));

        // R8 return address from word 4 via a jump
        reset_core();
        poke(12'd60, 32'h8000_0003);
        poke(12'd0, mk(4'hA, 1'b0, 12'd4));
        poke(12'd4, mk(4'h3, 1'b0, 12'd60));
        poke(12'd5, mk(4'h0, 1'b0, 12'd0));
        run_prog(cyc);
        peek(12'd60, w);
        chk("R8 link word", w, 32'h8000_0002 | (32'd6 << 2));
        chk("R3 jump target decode", {20'd0, pc_out}, 32'd6);
        chk("R2 cycles three instr", cyc, 32'd6);

        // R9 conditional jump cases
        for (int k = 0; k < 4; k++) begin
            logic [31:0] av;
            logic        sg, tsw, tk;
            case (k)
                0: begin av = 32'h8000_0000; sg = 1'b0; tsw = 1'b0; tk = 1'b1; end
                1: begin av = 32'h0000_0010; sg = 1'b1; tsw = 1'b1; tk = 1'b1; end
                2: begin av = 32'h0000_0010; sg = 1'b1; tsw = 1'b0; tk = 1'b0; end
                default: begin av = 32'h0000_0010; sg = 1'b0; tsw = 1'b1; tk = 1'b0; end
            endcase
            reset_core();
            t_switch = tsw;
            poke(12'd80, av);
            poke(12'd0, mk(4'h1, 1'b0, 12'd80));
            poke(12'd1, mk(4'hB, sg, 12'd10));
            poke(12'd2, mk(4'h0, 1'b0, 12'd0));
            poke(12'd10, mk(4'h0, 1'b0, 12'd0));
            run_prog(cyc);
            chk("R9 branch pc", {20'd0, pc_out}, tk ? 32'd11 : 32'd3);
        end
        t_switch = 1'b0;

        // R12 breakpoint match continues, mismatch stops then resumes
        for (int i = 0; i < 4; i++) begin
            reset_core();
            poke(12'd0, mk(4'h0, 1'b0, 12'(1 << (8 + i))));
            poke(12'd1, mk(4'h0, 1'b0, 12'd0));
            bp_sw = 4'(1 << i);
            run_prog(cyc);
            chk("R12 match pc", {20'd0, pc_out}, 32'd2);
            chk("R12 match reason", {30'd0, halt_reason}, 32'd1);
            reset_core();
            bp_sw = ~4'(1 << i);
            run_prog(cyc);
            chk("R12 mismatch pc", {20'd0, pc_out}, 32'd1);
            chk("R12 mismatch reason", {30'd0, halt_reason}, 32'd1);
            run_prog(cyc);
            chk("R12 resume pc", {20'd0, pc_out}, 32'd2);
            chk("R2 resume cycles", cyc, 32'd2);
        end
        bp_sw = 4'd0;

        // R13 input and output opcodes do nothing
        reset_core();
        poke(12'd7, 32'h0BAD_F00C);
        poke(12'd90, 32'h1357_2468);
        poke(12'd0, mk(4'h1, 1'b0, 12'd90));
        poke(12'd1, mk(4'h4, 1'b0, 12'd7));
        poke(12'd2, mk(4'h8, 1'b1, 12'd7));
        poke(12'd3, mk(4'h0, 1'b0, 12'd0));
        run_prog(cyc);
        chk("R13 acc", acc_out, 32'h1357_2468);
        chk("R13 pc", {20'd0, pc_out}, 32'd4);
        chk("R13 cycles", cyc, 32'd8);
        peek(12'd7, w);
        chk("R13 memory", w, 32'h0BAD_F00C);

        // R14 state held while idle
        a_keep = acc_out;
        p_keep = pc_out;
        t_switch = 1'b1;
        bp_sw = 4'hF;
        repeat (5) @(negedge clk);
        chk("R14 acc hold", acc_out, a_keep);
        chk("R14 pc hold", {20'd0, pc_out}, {20'd0, p_keep});
        chk("R14 still halted", {31'd0, halted}, 32'd1);
        t_switch = 1'b0;
        bp_sw = 4'd0;

        // directed arithmetic corners
        one_op(4'hE, 32'h7FFF_FFFE, 32'h0000_0002);
        one_op(4'hE, 32'h7FFF_FFFC, 32'h0000_0002);
        one_op(4'hF, 32'h8000_0000, 32'h0000_0002);
        one_op(4'hF, 32'h0000_0000, 32'h8000_0000);
        one_op(4'h5, 32'h4000_0000, 32'h8000_0000);
        one_op(4'h5, 32'h4000_0000, 32'h4000_0000);
        one_op(4'h5, 32'h0000_1000, 32'h0000_0000);
        one_op(4'h7, 32'h8000_0000, 32'h8000_0000);
        one_op(4'h6, 32'hFFFF_FFFE, 32'h0000_0006);
        one_op(4'hD, 32'hCAFE_BABE, 32'h1111_1111);

        // random mix
        for (int it = 0; it < 80; it++) begin
            one_op(ops[$urandom % 9], rnd_word(), rnd_word());
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule